// File: doc/BRIEF.md
# Byte-Lane Controller for an Asynchronous Static RAM

This block sits between a simple synchronous host port and an external asynchronous static RAM of 128K words by 16 bits. It turns each host request into a pin-level cycle on the memory. The memory has an active-low chip select, output enable, write strobe, and one active-low enable for each 8-bit lane. The host presents one request at a time with a valid/ready handshake. A request carries a word address, write data and a two-bit lane mask. Read data comes back with a one-cycle strobe.

Every phase length is a parameter counted in clock cycles. The integrator derives each one from the clock period and the memory's timing limits, rounded up. The controller adds no margin of its own. A write is framed by the overlap of chip select and write strobe. The controller turns its data drivers on only after the write strobe is already low, and holds output enable high for the whole write. A read is followed by idle turnaround cycles before the bus can be driven again. Every memory-side output comes straight from a flop.

Top module: `sram_byte_ctl`

## Requirements
- R1: `req_ready` is high only while the controller is idle. A request is taken on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` then stays low until the cycle sequence for that request has finished.
- R2: A write drives chip select low with the write strobe high for WR_SETUP cycles, then the write strobe low for WR_PULSE cycles, then the write strobe high with chip select still low for WR_HOLD cycles. Output enable stays high for the whole write.
- R3: During a write, the data drivers (`mem_dq_oe`) are off in the first cycle of the write-strobe pulse. They are on from the second pulse cycle to the last hold cycle, with `mem_dq_out` equal to the accepted write data. WR_PULSE is at least 2.
- R4: Mask bit 0 selects data bits 7:0 and drives `mem_lb_n` low while chip select is low. Mask bit 1 selects bits 15:8 and drives `mem_ub_n` low. A lane whose mask bit is 0 keeps its enable high, so a write with that bit clear leaves that byte in the memory unchanged.
- R5: A read holds chip select and output enable low, with the write strobe high, for RD_WAIT cycles. The bus is sampled on the edge that ends the last of those cycles. `rsp_valid` is high for exactly the following cycle, with `rsp_rdata` holding the sampled data.
- R6: In `rsp_rdata`, a byte whose mask bit was 0 reads as zero, whatever the memory bus carried in that lane.
- R7: After a read, RD_TURN cycles follow with all strobes high, the drivers off and `req_ready` low. Only then does the controller return to idle.
- R8: While chip select is low, `mem_addr` equals the accepted request address and does not change, even if `req_addr` changes.
- R9: In reset and while idle, chip select, output enable, write strobe and both lane enables are high, `mem_dq_oe` is low and `rsp_valid` is low. `req_ready` is high after reset.
- R10: Output enable and the write strobe are never low together, and the data drivers are never on while output enable is low or chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane mask, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| rsp_valid | output | 1 | Read data strobe, one cycle |
| rsp_rdata | output | 16 | Read data, unselected lanes zero |
| mem_addr | output | 17 | Memory address |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_lb_n | output | 1 | Lower lane enable, active low |
| mem_ub_n | output | 1 | Upper lane enable, active low |
| mem_dq_oe | output | 1 | Drive enable for the data bus |
| mem_dq_out | output | 16 | Data driven onto the bus |
| mem_dq_in | input | 16 | Data read from the bus |

## Verification
The hardest case to reach is a partial-lane access whose effect shows up only later. A single-lane write must leave the other byte intact, and a single-lane read must return zero in a lane where the memory model deliberately puts junk on the bus. To get there, the bench backs the ports with a behavioural memory. That memory latches data only on the rising edge of the write strobe, and only in enabled lanes. The bench then interleaves full, lower-only, upper-only and empty-mask writes at the same address, and reads each one back under every mask. After each request is accepted, the bench scrambles the request fields, which shows that address and data were latched.

// File: rtl/sram_ctl_pkg.sv
// Package: shared state encoding and helpers for the static RAM controller.
// Assumes: one request in flight at a time; phase lengths of at least one cycle.
package sram_ctl_pkg;

    // Controller phases, one per segment of a memory cycle.
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_WSET = 3'd1,
        ST_WPUL = 3'd2,
        ST_WHLD = 3'd3,
        ST_RACC = 3'd4,
        ST_RTRN = 3'd5
    } ctl_st_e;

    // Larger of two counts, used to size the shared phase counter.
    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // True in every phase where the memory must see chip select low.
    function automatic logic chip_sel(input ctl_st_e s);
        return (s == ST_WSET) || (s == ST_WPUL) || (s == ST_WHLD) || (s == ST_RACC);
    endfunction

endpackage

// File: rtl/sram_ctl_seq.sv
// Module: phase sequencer. It walks through setup, pulse and hold for writes,
// and through access and turnaround for reads, with one down-counter shared by all phases.
// Assumes: every length parameter is >= 1 and WR_PULSE >= 2.
module sram_ctl_seq
    import sram_ctl_pkg::*;
#(
    parameter int WR_SETUP = 1,
    parameter int WR_PULSE = 2,
    parameter int WR_HOLD  = 1,
    parameter int RD_WAIT  = 2,
    parameter int RD_TURN  = 1
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    req_valid,
    input  logic    req_write,
    output logic    req_ready,
    output logic    accept,
    output logic    cap_en,
    output logic    rsp_valid,
    output ctl_st_e st_q,
    output ctl_st_e st_d
);

    localparam int MAX_LEN = max2(max2(max2(WR_SETUP, WR_PULSE), max2(WR_HOLD, RD_WAIT)), RD_TURN);
    localparam int CNT_W   = (MAX_LEN < 2) ? 1 : $clog2(MAX_LEN);
    localparam logic [CNT_W-1:0] LD_WSET = CNT_W'(WR_SETUP - 1);
    localparam logic [CNT_W-1:0] LD_WPUL = CNT_W'(WR_PULSE - 1);
    localparam logic [CNT_W-1:0] LD_WHLD = CNT_W'(WR_HOLD - 1);
    localparam logic [CNT_W-1:0] LD_RACC = CNT_W'(RD_WAIT - 1);
    localparam logic [CNT_W-1:0] LD_RTRN = CNT_W'(RD_TURN - 1);

    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             last;

    assign last      = (cnt_q == '0);
    assign req_ready = (st_q == ST_IDLE);
    assign accept    = req_ready && req_valid;
    assign cap_en    = (st_q == ST_RACC) && last;

    // Next phase and counter reload: leave a phase when its counter reaches zero.
    always_comb begin
        st_d  = st_q;
        cnt_d = last ? cnt_q : cnt_q - 1'b1;
        unique case (st_q)
            ST_IDLE: if (req_valid) begin
                st_d  = req_write ? ST_WSET : ST_RACC;
                cnt_d = req_write ? LD_WSET : LD_RACC;
            end
            ST_WSET: if (last) begin st_d = ST_WPUL; cnt_d = LD_WPUL; end
            ST_WPUL: if (last) begin st_d = ST_WHLD; cnt_d = LD_WHLD; end
            ST_WHLD: if (last) begin st_d = ST_IDLE; cnt_d = '0;      end
            ST_RACC: if (last) begin st_d = ST_RTRN; cnt_d = LD_RTRN; end
            ST_RTRN: if (last) begin st_d = ST_IDLE; cnt_d = '0;      end
            default: begin st_d = ST_IDLE; cnt_d = '0; end
        endcase
    end

    // Phase and counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // Read strobe: high for the cycle after the bus is sampled.
    always_ff @(posedge clk) begin
        if (!rst_n) rsp_valid <= 1'b0;
        else        rsp_valid <= cap_en;
    end

endmodule

// File: rtl/sram_ctl_pins.sv
// Module: registered memory strobes, address and write data. Each output is
// computed from the next phase, so every pin comes straight from a flop with no glitches.
// Assumes: the phase pair (st_q, st_d) comes from sram_ctl_seq.
module sram_ctl_pins
    import sram_ctl_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ctl_st_e           st_q,
    input  ctl_st_e           st_d,
    input  logic              accept,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic              mem_dq_oe,
    output logic [DATA_W-1:0] mem_dq_out
);

    logic drive_d;

    // Drivers come on only in the second pulse cycle or later, and stay on through hold.
    assign drive_d = ((st_d == ST_WPUL) && (st_q == ST_WPUL)) || (st_d == ST_WHLD);

    // Strobe registers, high (inactive) in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_ce_n  <= 1'b1;
            mem_oe_n  <= 1'b1;
            mem_we_n  <= 1'b1;
            mem_dq_oe <= 1'b0;
        end else begin
            mem_ce_n  <= !chip_sel(st_d);
            mem_oe_n  <= !(st_d == ST_RACC);
            mem_we_n  <= !(st_d == ST_WPUL);
            mem_dq_oe <= drive_d;
        end
    end

    // Address and write data latched when a request is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr   <= '0;
            mem_dq_out <= '0;
        end else if (accept) begin
            mem_addr   <= req_addr;
            mem_dq_out <= req_wdata;
        end
    end

endmodule

// File: rtl/sram_ctl_lanes.sv
// Module: per-byte lane logic. It holds the lane mask, drives each lane's enable
// and captures each read byte, forcing unselected lanes to zero.
// Assumes: the data width is a whole number of bytes.
module sram_ctl_lanes
    import sram_ctl_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  ctl_st_e            st_d,
    input  logic               accept,
    input  logic               cap_en,
    input  logic [LANES-1:0]   req_mask,
    input  logic [8*LANES-1:0] mem_dq_in,
    output logic [LANES-1:0]   mem_be_n,
    output logic [8*LANES-1:0] rsp_rdata
);

    logic sel_d;
    assign sel_d = chip_sel(st_d);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic mask_q;
        logic mask_use;

        assign mask_use = accept ? req_mask[g] : mask_q;

        // Lane mask held for the length of the request.
        always_ff @(posedge clk) begin
            if (!rst_n)      mask_q <= 1'b0;
            else if (accept) mask_q <= req_mask[g];
        end

        // Lane enable is low only while the chip is selected and the lane is masked in.
        always_ff @(posedge clk) begin
            if (!rst_n) mem_be_n[g] <= 1'b1;
            else        mem_be_n[g] <= !(sel_d && mask_use);
        end

        // Read byte capture; a lane that is masked out returns zero.
        always_ff @(posedge clk) begin
            if (!rst_n)      rsp_rdata[8*g +: 8] <= '0;
            else if (cap_en) rsp_rdata[8*g +: 8] <= mask_q ? mem_dq_in[8*g +: 8] : 8'h00;
        end
    end

endmodule

// File: rtl/sram_byte_ctl.sv
// Module: top of the static RAM controller. It ties the sequencer, the pin registers
// and the byte lanes together, and maps the two lane enables onto named pins.
// Assumes: DATA_W = 16 (two lanes), one outstanding request, and lengths set by the integrator.
module sram_byte_ctl
    import sram_ctl_pkg::*;
#(
    parameter int ADDR_W   = 17,
    parameter int DATA_W   = 16,
    parameter int WR_SETUP = 1,
    parameter int WR_PULSE = 2,
    parameter int WR_HOLD  = 1,
    parameter int RD_WAIT  = 2,
    parameter int RD_TURN  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [1:0]        req_mask,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic              mem_lb_n,
    output logic              mem_ub_n,
    output logic              mem_dq_oe,
    output logic [DATA_W-1:0] mem_dq_out,
    input  logic [DATA_W-1:0] mem_dq_in
);

    localparam int LANES = DATA_W / 8;

    ctl_st_e          st_q, st_d;
    logic             accept, cap_en;
    logic [LANES-1:0] be_n;

    sram_ctl_seq #(
        .WR_SETUP(WR_SETUP), .WR_PULSE(WR_PULSE), .WR_HOLD(WR_HOLD),
        .RD_WAIT(RD_WAIT), .RD_TURN(RD_TURN)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_ready(req_ready), .accept(accept), .cap_en(cap_en),
        .rsp_valid(rsp_valid), .st_q(st_q), .st_d(st_d)
    );

    sram_ctl_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
        .clk(clk), .rst_n(rst_n), .st_q(st_q), .st_d(st_d), .accept(accept),
        .req_addr(req_addr), .req_wdata(req_wdata), .mem_addr(mem_addr),
        .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_dq_oe(mem_dq_oe), .mem_dq_out(mem_dq_out)
    );

    sram_ctl_lanes #(.LANES(LANES)) u_lanes (
        .clk(clk), .rst_n(rst_n), .st_d(st_d), .accept(accept), .cap_en(cap_en),
        .req_mask(req_mask[LANES-1:0]), .mem_dq_in(mem_dq_in),
        .mem_be_n(be_n), .rsp_rdata(rsp_rdata)
    );

    assign mem_lb_n = be_n[0];
    assign mem_ub_n = be_n[LANES-1];

endmodule

// File: rtl/sram_byte_ctl_chk.sv
// Module: protocol checker for sram_byte_ctl, attached with bind.
// Assumes: only the top module's ports are visible to it.
module sram_byte_ctl_chk #(
    parameter int ADDR_W = 17
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ce_n,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic              mem_dq_oe
);

    // R2
    we_inside_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> !mem_ce_n);

    // R10
    oe_we_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_oe_n && !mem_we_n));

    // R10
    no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (mem_oe_n && !mem_ce_n));

    // R3
    drive_after_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dq_oe) |-> (!mem_we_n && $past(!mem_we_n)));

    // R3
    hold_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mem_we_n) && !mem_ce_n) |-> mem_dq_oe);

    // R5
    rsp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R1
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_ce_n |-> !req_ready);

    // R8
    addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

endmodule

bind sram_byte_ctl sram_byte_ctl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_dq_oe(mem_dq_oe)
);

// File: tb/sim_sram_byte_ctl.sv
// Bench: a behavioural, cycle-by-cycle reference model (a queue of expected pin
// states) is compared at every falling edge; a behavioural memory backs the bus.
module sim_sram_byte_ctl;

    localparam int TB_WSET = 1;
    localparam int TB_WPUL = 3;
    localparam int TB_WHLD = 1;
    localparam int TB_RWAIT = 2;
    localparam int TB_RTURN = 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [16:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_mask = '0;
    logic        rsp_valid;
    logic [15:0] rsp_rdata;
    logic [16:0] mem_addr;
    logic        mem_ce_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n, mem_dq_oe;
    logic [15:0] mem_dq_out;
    logic [15:0] mem_dq_in = '0;

    int total = 0;
    int bad = 0;
    bit timed_out = 0;

    always #4 clk = ~clk;

    sram_byte_ctl #(
        .WR_SETUP(TB_WSET), .WR_PULSE(TB_WPUL), .WR_HOLD(TB_WHLD),
        .RD_WAIT(TB_RWAIT), .RD_TURN(TB_RTURN)
    ) u0 (.*);

    // Behavioural memory: latches on the rising write strobe and puts junk on unselected lanes.
    logic [15:0] sram [int];
    always @(posedge mem_we_n) begin
        if (!mem_ce_n && mem_dq_oe) begin
            logic [15:0] w;
            w = sram.exists(int'(mem_addr)) ? sram[int'(mem_addr)] : 16'h0;
            if (!mem_lb_n) w[7:0]  = mem_dq_out[7:0];
            if (!mem_ub_n) w[15:8] = mem_dq_out[15:8];
            sram[int'(mem_addr)] = w;
        end
    end
    always @(negedge clk) begin
        logic [15:0] r;
        r = sram.exists(int'(mem_addr)) ? sram[int'(mem_addr)] : 16'h0;
        if (!mem_ce_n && !mem_oe_n && mem_we_n)
            mem_dq_in <= {mem_ub_n ? 8'hA5 : r[15:8], mem_lb_n ? 8'h5A : r[7:0]};
        else
            mem_dq_in <= 16'hDEAD;
    end

    typedef struct {
        string       tag;
        logic        ce_n, oe_n, we_n, lb_n, ub_n, dq_oe, ready, rv;
        logic [16:0] addr;
        logic [15:0] dout;
        logic [15:0] rd;
    } exp_t;

    exp_t        expq [$];
    logic [15:0] refmem [int];

    task automatic chk(input string r, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h @%0t", r, what, act, exp, $time);
        end
    endtask

    function automatic exp_t idle_e();
        exp_t e;
        e.tag = "R9"; e.ce_n = 1; e.oe_n = 1; e.we_n = 1; e.lb_n = 1; e.ub_n = 1;
        e.dq_oe = 0; e.ready = 1; e.rv = 0; e.addr = '0; e.dout = '0; e.rd = '0;
        return e;
    endfunction

    // One cycle: compare every output with the model's expectation for this cycle.
    task automatic tick();
        exp_t e;
        @(negedge clk);
        e = (expq.size() != 0) ? expq.pop_front() : idle_e();
        chk("R1", "req_ready", 32'(req_ready), 32'(e.ready));
        chk(e.tag, "ce_n", 32'(mem_ce_n), 32'(e.ce_n));
        chk(e.tag, "oe_n", 32'(mem_oe_n), 32'(e.oe_n));
        chk(e.tag, "we_n", 32'(mem_we_n), 32'(e.we_n));
        chk("R4", "lb_n", 32'(mem_lb_n), 32'(e.lb_n));
        chk("R4", "ub_n", 32'(mem_ub_n), 32'(e.ub_n));
        chk("R3", "dq_oe", 32'(mem_dq_oe), 32'(e.dq_oe));
        chk("R5", "rsp_valid", 32'(rsp_valid), 32'(e.rv));
        if (!e.ce_n)  chk("R8", "mem_addr", 32'(mem_addr), 32'(e.addr));
        if (e.dq_oe)  chk("R3", "dq_out", 32'(mem_dq_out), 32'(e.dout));
        if (e.rv)     chk("R6", "rsp_rdata", 32'(rsp_rdata), 32'(e.rd));
        chk("R10", "oe_we_overlap", 32'(!mem_oe_n && !mem_we_n), 32'h0);
        chk("R10", "drive_contention", 32'(mem_dq_oe && (!mem_oe_n || mem_ce_n)), 32'h0);
    endtask

    task automatic issue(input bit wr, input logic [16:0] a, input logic [15:0] d, input logic [1:0] m);
        exp_t e;
        logic [15:0] cur;
        while (expq.size() != 0) tick();
        tick();
        req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
        e = idle_e();
        e.ready = 0; e.ce_n = 0; e.addr = a; e.dout = d;
        e.lb_n = !m[0]; e.ub_n = !m[1];
        cur = refmem.exists(int'(a)) ? refmem[int'(a)] : 16'h0;
        if (wr) begin
            e.tag = "R2";
            for (int i = 0; i < TB_WSET; i++) expq.push_back(e);
            e.we_n = 0;
            for (int i = 0; i < TB_WPUL; i++) begin e.dq_oe = (i > 0); expq.push_back(e); end
            e.we_n = 1; e.dq_oe = 1;
            for (int i = 0; i < TB_WHLD; i++) expq.push_back(e);
            if (m[0]) cur[7:0]  = d[7:0];
            if (m[1]) cur[15:8] = d[15:8];
            refmem[int'(a)] = cur;
        end else begin
            e.tag = "R5"; e.oe_n = 0;
            for (int i = 0; i < TB_RWAIT; i++) expq.push_back(e);
            e = idle_e(); e.tag = "R7"; e.ready = 0;
            for (int i = 0; i < TB_RTURN; i++) begin
                e.rv = (i == 0);
                e.rd = {m[1] ? cur[15:8] : 8'h00, m[0] ? cur[7:0] : 8'h00};
                expq.push_back(e);
            end
        end
        tick();
        req_valid = 0; req_addr = ~a; req_wdata = ~d; req_mask = ~m; req_write = ~wr;
    endtask

    task automatic run_all();
        logic [16:0] a;
        logic [15:0] d;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R9", "reset ce_n", 32'(mem_ce_n), 32'h1);
        chk("R9", "reset rsp_valid", 32'(rsp_valid), 32'h0);
        chk("R9", "reset dq_oe", 32'(mem_dq_oe), 32'h0);
        rst_n = 1;
        tick();
        issue(1, 17'h00010, 16'h1234, 2'b11);
        issue(0, 17'h00010, 16'h0000, 2'b11);
        issue(1, 17'h00010, 16'hAB99, 2'b01);
        issue(0, 17'h00010, 16'h0000, 2'b11);
        issue(1, 17'h00010, 16'h77CC, 2'b10);
        issue(0, 17'h00010, 16'h0000, 2'b01);
        issue(0, 17'h00010, 16'h0000, 2'b10);
        issue(1, 17'h00010, 16'hFFFF, 2'b00);
        issue(0, 17'h00010, 16'h0000, 2'b11);
        issue(0, 17'h00010, 16'h0000, 2'b00);
        issue(1, 17'h1FFFF, 16'hCAFE, 2'b11);
        issue(1, 17'h00000, 16'h0F0F, 2'b11);
        issue(0, 17'h1FFFF, 16'h0000, 2'b11);
        issue(0, 17'h00000, 16'h0000, 2'b11);
        a = 17'h00155; d = 16'h9E37;
        for (int i = 0; i < 40; i++) begin
            a = {a[15:0], a[16] ^ a[13]} ^ 17'(i);
            d = d * 16'd5 + 16'h3B;
            issue(i[0], a & 17'h0000F, d, 2'(i >> 1));
        end
        while (expq.size() != 0) tick();
        repeat (3) tick();
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (20000) @(posedge clk);
                timed_out = 1;
            end
        join_any
        disable fork;
        if (timed_out) begin
            total++; bad++;
            $display("FAIL watchdog R1 actual=hung expected=done");
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule